// File: doc/BRIEF.md
# Prescaled Up / Up-Down Timer Timebase

This block is the time reference for a timer channel group. It holds a 16-bit count that moves between a programmable lower bound (the start value) and a programmable upper bound (the modulus). One of three count sources can drive it: the system clock, a fixed-frequency enable pulse, or an external clock pin. A fourth setting stops it. The chosen source feeds a 7-bit power-of-two prescaler, and each prescaler tick advances the count by one step.

Two counting modes exist. Up mode climbs from the start value to the modulus and reloads the start value. Up-down mode, used for centre-aligned waveforms, climbs to the modulus and then falls back to the start value, reversing at both bounds. Channel logic reads the count, the direction, a tick strobe that marks every count update, and an event strobe that marks each reload or turnaround. A restart request puts the count back to the start value, direction up, on the next tick. The count is raw binary, so downstream logic may read it as unsigned or as signed.

Top module: `tmr_timebase`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, count_o is 0, dir_down_o is 0 (0 means counting up), and tick_o and event_o are 0.
- R2: clk_sel_i picks the count source. 00 gives no source ticks, so the count, prescaler and strobes hold. 01 gives a source tick every clock cycle. 10 gives one in each cycle where fixed_en_i is 1. 11 gives exactly one per rising edge of ext_clk_i, whatever the length of the high level.
- R3: With clk_sel_i = 11 and presc_i = 0, count_o moves at the third rising clk_i edge that samples ext_clk_i high. The first edge is the one that first sees the pin high. The count is unchanged after the first and second of those edges.
- R4: presc_i = p gives one count tick per 2^p source ticks (1 to 128). count_o and dir_down_o change only on a count tick. tick_o is 1 for exactly the cycle in which the updated count first shows.
- R5: In up mode (updown_i = 0), each tick adds 1 to the count. When the count is at or above modulus_i, the next tick loads start_i instead. The period is modulus − start + 1 ticks, and dir_down_o stays 0.
- R6: In up mode, event_o is 1 in the cycle the reloaded start value first shows, and only then.
- R7: In up-down mode (updown_i = 1, with modulus > start), the count rises by 1 per tick until it equals modulus_i. The next tick sets dir_down_o to 1 and gives modulus − 1. The count then falls until it equals start_i, and the next tick clears dir_down_o and gives start + 1.
- R8: In up-down mode, event_o is 1 in the cycle each reversal first shows: at modulus − 1 with the direction newly down, and at start + 1 with the direction newly up.
- R9: A one-cycle pulse on restart_i is held until the next count tick. That tick loads start_i and clears dir_down_o without raising event_o. Until that tick the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fixed_en_i | input | 1 | Fixed-frequency enable pulse source |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| clk_sel_i | input | 2 | Source select: 00 off, 01 system, 10 fixed enable, 11 external |
| presc_i | input | 3 | Prescale exponent p, divide by 2^p |
| start_i | input | 16 | Lower bound of the count and its reload value |
| modulus_i | input | 16 | Upper bound of the count |
| updown_i | input | 1 | 0 up counting, 1 up-down counting |
| restart_i | input | 1 | Request to reload the start value on the next tick |
| count_o | output | 16 | Current count |
| dir_down_o | output | 1 | 1 while counting down |
| tick_o | output | 1 | One cycle with each count update |
| event_o | output | 1 | One cycle with each reload or turnaround |

## Verification
With the system clock selected and no prescaling, a count update shows in the cycle after the edge that consumes the tick. The bench drives on falling edges and samples on the next falling edge, one step per clock. An external-pin tick shows only after the synchronizer and edge detector, so the bench checks the count after the first, second and third edges that see the pin high, and it expects the change only after the third. Prescaled ticks are timed by counting cycles between tick_o pulses, so the prescaler phase left by an earlier test does not matter. Restart and reversal checks sample the strobes and direction in the same cycle as the new count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_SYS   = 2'b01,
    SRC_FIXED = 2'b10,
    SRC_EXT   = 2'b11
  } src_sel_e;
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fixed_en_i,
  input  logic       ext_clk_i,
  input  logic [1:0] clk_sel_i,
  output logic       src_en_o
);
  import tmr_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   ext_rise;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= ext_clk_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b0;
    else ext_prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev_q;

  always_comb begin
    unique case (src_sel_e'(clk_sel_i))
      SRC_SYS:   src_en_o = 1'b1;
      SRC_FIXED: src_en_o = fixed_en_i;
      SRC_EXT:   src_en_o = ext_rise;
      default:   src_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            src_en_i,
  input  logic [PS_W-1:0] presc_i,
  output logic            tick_o
);
  localparam int unsigned PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W:0]   lim_full;
  logic [PRE_W-1:0] lim;
  logic             wrap;

  assign lim_full = ({{PRE_W{1'b0}}, 1'b1} << presc_i) - 1'b1;
  assign lim      = lim_full[PRE_W-1:0];
  // >= so a shrinking ratio never strands the counter above its limit
  assign wrap     = (pcnt_q >= lim);
  assign tick_o   = src_en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else if (src_en_i) pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] modulus_i,
  input  logic             updown_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             tick_o,
  output logic             event_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             down_q, pend_q, tick_q, evt_q;
  logic             do_restart, at_top, at_bot;

  assign do_restart = restart_i | pend_q;
  assign at_top     = (cnt_q >= modulus_i);
  assign at_bot     = (cnt_q <= start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      pend_q <= 1'b0;
      tick_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      tick_q <= tick_i;
      evt_q  <= 1'b0;
      if (tick_i) pend_q <= 1'b0;
      else if (restart_i) pend_q <= 1'b1;
      if (tick_i) begin
        if (do_restart) begin
          cnt_q  <= start_i;
          down_q <= 1'b0;
        end else if (!updown_i) begin
          down_q <= 1'b0;
          if (at_top) begin
            cnt_q <= start_i;
            evt_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (!down_q) begin
          if (at_top) begin
            cnt_q  <= cnt_q - 1'b1;
            down_q <= 1'b1;
            evt_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (at_bot) begin
            cnt_q  <= cnt_q + 1'b1;
            down_q <= 1'b0;
            evt_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign count_o    = cnt_q;
  assign dir_down_o = down_q;
  assign tick_o     = tick_q;
  assign event_o    = evt_q;
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PS_W        = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fixed_en_i,
  input  logic             ext_clk_i,
  input  logic [1:0]       clk_sel_i,
  input  logic [PS_W-1:0]  presc_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] modulus_i,
  input  logic             updown_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             tick_o,
  output logic             event_o
);
  logic src_en, cnt_tick;

  tmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fixed_en_i (fixed_en_i),
    .ext_clk_i  (ext_clk_i),
    .clk_sel_i  (clk_sel_i),
    .src_en_o   (src_en)
  );

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_en_i (src_en),
    .presc_i  (presc_i),
    .tick_o   (cnt_tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (cnt_tick),
    .start_i    (start_i),
    .modulus_i  (modulus_i),
    .updown_i   (updown_i),
    .restart_i  (restart_i),
    .count_o    (count_o),
    .dir_down_o (dir_down_o),
    .tick_o     (tick_o),
    .event_o    (event_o)
  );
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       clk_sel_i,
  input logic [CNT_W-1:0] start_i,
  input logic             updown_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_down_o,
  input logic             tick_o,
  input logic             event_o
);
  AST_OFF_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clk_sel_i) == 2'b00) |-> !tick_o);  // R2
  AST_COUNT_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_o) |-> tick_o);  // R4
  AST_DIR_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_down_o) |-> tick_o);  // R4
  AST_EVENT_WITH_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> tick_o);  // R6
  AST_UP_RELOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !$past(updown_i)) |-> (count_o == $past(start_i)));  // R6
  AST_UP_DIR_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !$past(updown_i)) |-> !dir_down_o);  // R5
  AST_TURN_FLIPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && $past(updown_i)) |-> (dir_down_o != $past(dir_down_o)));  // R8
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_sel_i  (clk_sel_i),
  .start_i    (start_i),
  .updown_i   (updown_i),
  .count_o    (count_o),
  .dir_down_o (dir_down_o),
  .tick_o     (tick_o),
  .event_o    (event_o)
);

// File: tb/tb_tmr_timebase.sv
module tb_tmr_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fixed_en = 1'b0, ext_clk = 1'b0, updown = 1'b0, restart = 1'b0;
  logic [1:0]  clk_sel = 2'b01;
  logic [2:0]  presc = 3'd0;
  logic [15:0] start_v = 16'd0, mod_v = 16'd1000;
  logic [15:0] count;
  logic        dir_down, tick, evt;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_timebase dut (
    .clk_i(clk), .rst_ni(rst_n), .fixed_en_i(fixed_en), .ext_clk_i(ext_clk),
    .clk_sel_i(clk_sel), .presc_i(presc), .start_i(start_v), .modulus_i(mod_v),
    .updown_i(updown), .restart_i(restart), .count_o(count),
    .dir_down_o(dir_down), .tick_o(tick), .event_o(evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1'b1;
    step();
    restart = 1'b0;
  endtask

  task automatic t_reset();
    chk(count == 0, "R1 count", count, 0);
    chk(dir_down == 0, "R1 dir", dir_down, 0);
    chk(tick == 0 && evt == 0, "R1 strobes", {tick, evt}, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_up();
    int exp_c[6] = '{10, 11, 12, 13, 10, 11};
    int exp_e[6] = '{0, 0, 0, 0, 1, 0};
    clk_sel = 2'b01; presc = 0; updown = 0; start_v = 10; mod_v = 13;
    restart = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      restart = 1'b0;
      chk(count == exp_c[i], "R5 up count", count, exp_c[i]);
      chk(evt == exp_e[i], "R6 up event", evt, exp_e[i]);
      chk(dir_down == 0, "R5 up dir", dir_down, 0);
      chk(tick == 1, "R4 tick each cycle", tick, 1);
    end
  endtask

  task automatic t_updown();
    int exp_c[11] = '{5, 6, 7, 8, 7, 6, 5, 6, 7, 8, 7};
    int exp_d[11] = '{0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 1};
    int exp_e[11] = '{0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 1};
    clk_sel = 2'b01; presc = 0; updown = 1; start_v = 5; mod_v = 8;
    restart = 1'b1;
    for (int i = 0; i < 11; i++) begin
      step();
      restart = 1'b0;
      chk(count == exp_c[i], "R7 updown count", count, exp_c[i]);
      chk(dir_down == exp_d[i], "R7 updown dir", dir_down, exp_d[i]);
      chk(evt == exp_e[i], "R8 turnaround event", evt, exp_e[i]);
    end
    // restart while descending
    do_restart();
    chk(count == 5, "R9 restart count", count, 5);
    chk(dir_down == 0, "R9 restart dir", dir_down, 0);
    chk(evt == 0, "R9 restart no event", evt, 0);
    step();
    chk(count == 6, "R9 climbs after restart", count, 6);
  endtask

  task automatic t_off();
    logic [15:0] c0;
    clk_sel = 2'b00;
    step();
    c0 = count;
    step(6);
    chk(count == c0, "R2 off holds count", count, c0);
    chk(tick == 0, "R2 off no tick", tick, 0);
  endtask

  task automatic t_fixed();
    logic [15:0] c0;
    clk_sel = 2'b10; presc = 0; updown = 0; start_v = 0; mod_v = 1000;
    fixed_en = 1'b1; do_restart(); fixed_en = 1'b0;
    step();
    c0 = count;
    for (int k = 1; k <= 3; k++) begin
      step(3);
      chk(count == c0 + k - 1, "R2 fixed idle holds", count, c0 + k - 1);
      fixed_en = 1'b1;
      step();
      fixed_en = 1'b0;
      chk(count == c0 + k, "R2 fixed pulse counts", count, c0 + k);
    end
  endtask

  task automatic t_ext();
    logic [15:0] c0;
    clk_sel = 2'b11; presc = 0;
    step(4);
    c0 = count;
    ext_clk = 1'b1;
    step();
    chk(count == c0, "R3 ext after 1st edge", count, c0);
    step();
    chk(count == c0, "R3 ext after 2nd edge", count, c0);
    step();
    chk(count == c0 + 1, "R3 ext after 3rd edge", count, c0 + 1);
    step(6);
    chk(count == c0 + 1, "R2 ext one tick per rise", count, c0 + 1);
    ext_clk = 1'b0;
    step(4);
    chk(count == c0 + 1, "R2 ext falling ignored", count, c0 + 1);
  endtask

  task automatic measure(input logic [2:0] p, input int exp_gap);
    int gap;
    logic [15:0] c0;
    clk_sel = 2'b01; presc = p; updown = 0; start_v = 0; mod_v = 1000;
    gap = 0;
    while (tick !== 1'b1 && gap < 400) begin step(); gap++; end
    c0 = count;
    gap = 0;
    do begin step(); gap++; end while (tick !== 1'b1 && gap < 400);
    chk(gap == exp_gap, "R4 prescale interval", gap, exp_gap);
    chk(count == c0 + 1, "R4 one step per tick", count, c0 + 1);
  endtask

  task automatic t_restart_presc();
    logic [15:0] c0;
    int gap;
    clk_sel = 2'b01; presc = 2; updown = 0; start_v = 300; mod_v = 1000;
    gap = 0;
    while (tick !== 1'b1 && gap < 40) begin step(); gap++; end
    c0 = count;
    do_restart();
    chk(count == c0, "R9 restart waits for tick", count, c0);
    gap = 0;
    while (tick !== 1'b1 && gap < 40) begin step(); gap++; end
    chk(count == 300, "R9 restart loads start", count, 300);
    chk(evt == 0, "R9 restart no event", evt, 0);
  endtask

  initial begin
    step(3);
    t_reset();
    t_up();
    t_updown();
    t_off();
    t_fixed();
    t_ext();
    measure(3'd2, 4);
    measure(3'd7, 128);
    t_restart_presc();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule